// File: doc/BRIEF.md
# Tagged Floating-Point Register Stack

This block holds eight 80-bit extended-format values arranged as a circular stack. A 3-bit top pointer selects which physical register is the current top. Every slot is named relative to that pointer, so slot i is physical register (top + i) mod 8 and slot 0 is the top. One command is accepted per clock: push, pop, store into a slot, exchange a slot with the top, read-check a slot, or initialise. The operand arrives already in 80-bit extended format: 1 sign bit, a 15-bit exponent with bias 16383, and a 64-bit significand with an explicit integer bit.

Every register has a 2-bit tag. The tag is computed whenever a value is written, by classifying the incoming encoding. A push onto a slot that is not empty is an overflow. A pop, read or exchange that touches an empty slot is an underflow. Neither case wraps silently. The command has no effect on the state, and the block raises a one-cycle stack-fault pulse and a one-cycle invalid-operation pulse. Arithmetic, rounding, format conversion and instruction decode are done by neighbouring blocks.

Top module: `fp_tag_stack`

## Requirements
- R1: After reset, and one cycle after an initialise command (cmdOp=5), topPtr is 0 and tagWord is 16'hFFFF (every tag empty). Register contents are zero after reset and are not changed by initialise.
- R2: rdData shows the contents of physical register (topPtr + rdSlot) mod 8. Tag bits [2i+1:2i] of tagWord hold the tag of slot i, so slot 0 is in bits 1:0 and slot 7 is in bits 15:14.
- R3: A push (cmdOp=1) whose target register (topPtr - 1) mod 8 is tagged empty decrements topPtr modulo 8 and writes wrData into the new slot 0. The previous slot 0 becomes slot 1.
- R4: A push whose target register is not tagged empty is an overflow. topPtr, all register contents and all tags are left unchanged.
- R5: A pop (cmdOp=2) of a non-empty slot 0 increments topPtr modulo 8 and marks the vacated register empty, so that register shows as slot 7. Register contents are not changed.
- R6: A pop of an empty slot 0, a read-check (cmdOp=6) of an empty slot slotSel, or an exchange in which either slot is empty is an underflow. It changes no state.
- R7: An exchange (cmdOp=4) of two non-empty slots swaps the contents and tags of slot 0 and slot slotSel. topPtr is unchanged.
- R8: A store (cmdOp=3) writes wrData and its tag into slot slotSel, whatever that slot's previous tag was. topPtr is unchanged and no fault is raised.
- R9: A written value is tagged as follows:
  - special (10) when the exponent is all ones;
  - zero (01) when the exponent and significand are both zero;
  - special (10) when the exponent is zero and the significand is not;
  - special (10) when the exponent is in range and the integer bit (bit 63) is 0;
  - valid (00) otherwise.
  The empty tag is 11.
- R10: stackFault and invalidOp are both high for exactly the cycle after an overflow or underflow command, and low after any other command or a NOP (cmdOp=0).
- R11: Each command is sampled on a rising clock edge. Its effect on topPtr, tagWord and rdData is visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdOp | input | 3 | Command: 0 nop, 1 push, 2 pop, 3 store, 4 exchange, 5 init, 6 read-check |
| slotSel | input | 3 | Relative slot for store, exchange and read-check |
| wrData | input | 80 | Extended-format operand for push and store |
| rdSlot | input | 3 | Relative slot shown on rdData |
| rdData | output | 80 | Contents of the slot named by rdSlot |
| topPtr | output | 3 | Physical index of slot 0 |
| tagWord | output | 16 | Packed tags of slots 0 to 7 |
| stackFault | output | 1 | One-cycle pulse on overflow or underflow |
| invalidOp | output | 1 | One-cycle pulse raised with every stack fault |

## Verification
A command is captured on a rising edge. Its new topPtr, tagWord and slot contents are due immediately after that edge. rdData follows rdSlot combinationally, and the fault pulses sit in the single cycle after the faulting command. The bench drives each command at a falling edge and applies it to its behavioural model at the next rising edge. At the following falling edge it compares every output against the model, sweeping rdSlot across all eight slots inside that half period, so each result is checked in the exact cycle it is due. The fault outputs are compared again after every subsequent command, which confirms that each pulse lasts one cycle only.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
  localparam int EXP_W = 15;
  localparam int SIG_W = 64;
  localparam int REG_W = 1 + EXP_W + SIG_W;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_STORE = 3'd3,
    OP_XCHG  = 3'd4,
    OP_INIT  = 3'd5,
    OP_READ  = 3'd6
  } stkOp_e;

  localparam logic [1:0] TAG_VALID   = 2'b00;
  localparam logic [1:0] TAG_ZERO    = 2'b01;
  localparam logic [1:0] TAG_SPECIAL = 2'b10;
  localparam logic [1:0] TAG_EMPTY   = 2'b11;

  // Strobes from control to datapath; at most one is set per cycle.
  typedef struct packed {
    logic push;
    logic pop;
    logic store;
    logic xchg;
    logic init;
  } stkStrobe_t;

  function automatic logic [1:0] classifyExt(input logic [REG_W-1:0] v);
    logic [EXP_W-1:0] expo;
    logic [SIG_W-1:0] sig;
    expo = v[SIG_W +: EXP_W];
    sig  = v[SIG_W-1:0];
    if (&expo)                  return TAG_SPECIAL; // infinity or NaN
    else if (expo == '0)        return (sig == '0) ? TAG_ZERO : TAG_SPECIAL;
    else if (!sig[SIG_W-1])     return TAG_SPECIAL; // unnormal
    else                        return TAG_VALID;
  endfunction
endpackage

// File: rtl/fpstk_ctrl.sv
module fpstk_ctrl
  import fpstk_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       cmdOp,
  input  logic [1:0]       tagTop,
  input  logic [1:0]       tagSel,
  input  logic [1:0]       tagBelow,
  output stkStrobe_t       strobe,
  output logic [PTR_W-1:0] top,
  output logic             fault
);
  stkOp_e op;
  logic isPush, isPop, isStore, isXchg, isInit, isRead;
  logic overflow, underflow;

  assign op = stkOp_e'(cmdOp);

  always_comb begin
    isPush  = (op == OP_PUSH);
    isPop   = (op == OP_POP);
    isStore = (op == OP_STORE);
    isXchg  = (op == OP_XCHG);
    isInit  = (op == OP_INIT);
    isRead  = (op == OP_READ);
    overflow  = isPush && (tagBelow != TAG_EMPTY);
    underflow = (isPop && (tagTop == TAG_EMPTY))
             || (isRead && (tagSel == TAG_EMPTY))
             || (isXchg && ((tagTop == TAG_EMPTY) || (tagSel == TAG_EMPTY)));
    strobe.push  = isPush && !overflow;
    strobe.pop   = isPop && (tagTop != TAG_EMPTY);
    strobe.store = isStore;
    strobe.xchg  = isXchg && !underflow;
    strobe.init  = isInit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      top   <= '0;
      fault <= 1'b0;
    end else begin
      if (strobe.init)      top <= '0;
      else if (strobe.push) top <= top - PTR_W'(1);
      else if (strobe.pop)  top <= top + PTR_W'(1);
      fault <= overflow || underflow;
    end
  end
endmodule

// File: rtl/fpstk_data.sv
module fpstk_data
  import fpstk_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  stkStrobe_t         strobe,
  input  logic [PTR_W-1:0]   top,
  input  logic [PTR_W-1:0]   slotSel,
  input  logic [REG_W-1:0]   wrData,
  input  logic [PTR_W-1:0]   rdSlot,
  output logic [REG_W-1:0]   rdData,
  output logic [2*DEPTH-1:0] tagWord,
  output logic [1:0]         tagTop,
  output logic [1:0]         tagSel,
  output logic [1:0]         tagBelow
);
  logic [REG_W-1:0] regs [DEPTH];
  logic [1:0]       tags [DEPTH];
  logic [PTR_W-1:0] idxSel, idxBelow, idxRd;
  logic [1:0]       wrTag;

  assign idxSel   = top + slotSel;
  assign idxBelow = top - PTR_W'(1);
  assign idxRd    = top + rdSlot;
  assign wrTag    = classifyExt(wrData);

  assign rdData   = regs[idxRd];
  assign tagTop   = tags[top];
  assign tagSel   = tags[idxSel];
  assign tagBelow = tags[idxBelow];

  // Tag word is packed in relative slot order.
  for (genvar g = 0; g < DEPTH; g++) begin : gTagPack
    logic [PTR_W-1:0] phys;
    assign phys = top + PTR_W'(g);
    assign tagWord[2*g +: 2] = tags[phys];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int j = 0; j < DEPTH; j++) begin
        regs[j] <= '0;
        tags[j] <= TAG_EMPTY;
      end
    end else begin
      for (int j = 0; j < DEPTH; j++) begin
        if (strobe.init) begin
          tags[j] <= TAG_EMPTY;
        end else if (strobe.push && (idxBelow == PTR_W'(j))) begin
          regs[j] <= wrData;
          tags[j] <= wrTag;
        end else if (strobe.pop && (top == PTR_W'(j))) begin
          tags[j] <= TAG_EMPTY;
        end else if (strobe.store && (idxSel == PTR_W'(j))) begin
          regs[j] <= wrData;
          tags[j] <= wrTag;
        end else if (strobe.xchg && (top == PTR_W'(j))) begin
          regs[j] <= regs[idxSel];
          tags[j] <= tags[idxSel];
        end else if (strobe.xchg && (idxSel == PTR_W'(j))) begin
          regs[j] <= regs[top];
          tags[j] <= tags[top];
        end
      end
    end
  end
endmodule

// File: rtl/fp_tag_stack.sv
module fp_tag_stack
  import fpstk_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         cmdOp,
  input  logic [PTR_W-1:0]   slotSel,
  input  logic [REG_W-1:0]   wrData,
  input  logic [PTR_W-1:0]   rdSlot,
  output logic [REG_W-1:0]   rdData,
  output logic [PTR_W-1:0]   topPtr,
  output logic [2*DEPTH-1:0] tagWord,
  output logic               stackFault,
  output logic               invalidOp
);
  stkStrobe_t strobe;
  logic [1:0] tagTop, tagSel, tagBelow;
  logic       fault;

  fpstk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdOp(cmdOp),
    .tagTop(tagTop), .tagSel(tagSel), .tagBelow(tagBelow),
    .strobe(strobe), .top(topPtr), .fault(fault)
  );

  fpstk_data #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .top(topPtr),
    .slotSel(slotSel), .wrData(wrData), .rdSlot(rdSlot),
    .rdData(rdData), .tagWord(tagWord),
    .tagTop(tagTop), .tagSel(tagSel), .tagBelow(tagBelow)
  );

  assign stackFault = fault;
  assign invalidOp  = fault;
endmodule

// File: rtl/fp_tag_stack_chk.sv
module fp_tag_stack_chk #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input logic               clk,
  input logic               rstN,
  input logic [2:0]         cmdOp,
  input logic [PTR_W-1:0]   slotSel,
  input logic [PTR_W-1:0]   topPtr,
  input logic [2*DEPTH-1:0] tagWord,
  input logic               stackFault
);
  logic [1:0] relTop, relBelow, relSel;
  assign relTop   = tagWord[1:0];
  assign relBelow = tagWord[2*DEPTH-1 -: 2];
  assign relSel   = tagWord[2*slotSel +: 2];

  // R3
  push_moves_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == 3'd1 && relBelow == 2'b11) |=> (topPtr == $past(topPtr) - PTR_W'(1)) && !stackFault);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == 3'd1 && relBelow != 2'b11) |=> stackFault && $stable(topPtr) && $stable(tagWord));

  // R5
  pop_vacates_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == 3'd2 && relTop != 2'b11) |=> (topPtr == $past(topPtr) + PTR_W'(1)) && (tagWord[2*DEPTH-1 -: 2] == 2'b11));

  // R6
  pop_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == 3'd2 && relTop == 2'b11) |=> stackFault && $stable(topPtr) && $stable(tagWord));

  // R7
  xchg_keeps_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == 3'd4 && relTop != 2'b11 && relSel != 2'b11) |=> $stable(topPtr) && !stackFault);

  // R8
  store_keeps_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == 3'd3) |=> $stable(topPtr) && !stackFault);

  // R1
  init_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == 3'd5) |=> (topPtr == '0) && (&tagWord) && !stackFault);
endmodule

bind fp_tag_stack fp_tag_stack_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .cmdOp(cmdOp), .slotSel(slotSel),
  .topPtr(topPtr), .tagWord(tagWord), .stackFault(stackFault)
);

// File: tb/fp_tag_stack_bench.sv
`timescale 1ns/100ps
module fp_tag_stack_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  cmdOp = 3'd0;
  logic [2:0]  slotSel = 3'd0;
  logic [79:0] wrData = '0;
  logic [2:0]  rdSlot = 3'd0;
  logic [79:0] rdData;
  logic [2:0]  topPtr;
  logic [15:0] tagWord;
  logic        stackFault, invalidOp;

  int checks = 0;
  int fails = 0;

  // behavioural reference state
  logic [79:0] mReg [8];
  logic [1:0]  mTag [8];
  int          mTop;
  logic        mFault;

  always #5 clk = ~clk;

  fp_tag_stack u_fp_tag_stack (
    .clk(clk), .rstN(rstN), .cmdOp(cmdOp), .slotSel(slotSel),
    .wrData(wrData), .rdSlot(rdSlot), .rdData(rdData), .topPtr(topPtr),
    .tagWord(tagWord), .stackFault(stackFault), .invalidOp(invalidOp)
  );

  localparam logic [79:0] V_ONE    = 80'h3FFF_8000_0000_0000_0000;
  localparam logic [79:0] V_TWO    = 80'h4000_8000_0000_0000_0000;
  localparam logic [79:0] V_NEGZ   = 80'h8000_0000_0000_0000_0000;
  localparam logic [79:0] V_INF    = 80'h7FFF_8000_0000_0000_0000;
  localparam logic [79:0] V_NAN    = 80'hFFFF_C000_0000_0000_1234;
  localparam logic [79:0] V_DENORM = 80'h0000_0000_0000_0000_0001;
  localparam logic [79:0] V_UNNORM = 80'h4000_4000_0000_0000_0000;
  localparam logic [79:0] V_NEGBIG = 80'hC123_F000_0000_0000_00AB;

  function automatic logic [1:0] refTag(input logic [79:0] v);
    if (v[78:64] == 15'h7FFF) return 2'b10;
    if (v[78:64] == 15'h0000) begin
      if (v[63:0] == 64'd0) return 2'b01;
      return 2'b10;
    end
    if (v[63] == 1'b0) return 2'b10;
    return 2'b00;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic modelApply(input int op, input int sel, input logic [79:0] d);
    int p, t;
    logic [79:0] tv;
    logic [1:0]  tt;
    mFault = 1'b0;
    p = (mTop + sel) % 8;
    case (op)
      1: begin
        t = (mTop + 7) % 8;
        if (mTag[t] != 2'b11) mFault = 1'b1;
        else begin mReg[t] = d; mTag[t] = refTag(d); mTop = t; end
      end
      2: begin
        if (mTag[mTop] == 2'b11) mFault = 1'b1;
        else begin mTag[mTop] = 2'b11; mTop = (mTop + 1) % 8; end
      end
      3: begin mReg[p] = d; mTag[p] = refTag(d); end
      4: begin
        if (mTag[mTop] == 2'b11 || mTag[p] == 2'b11) mFault = 1'b1;
        else begin
          tv = mReg[mTop]; tt = mTag[mTop];
          mReg[mTop] = mReg[p]; mTag[mTop] = mTag[p];
          mReg[p] = tv; mTag[p] = tt;
        end
      end
      5: begin
        for (int k = 0; k < 8; k++) mTag[k] = 2'b11;
        mTop = 0;
      end
      6: if (mTag[p] == 2'b11) mFault = 1'b1;
      default: ;
    endcase
  endtask

  // Called at a falling edge: compares all outputs with the model (R2 sweep).
  task automatic compareAll(input string req);
    logic [15:0] expTags;
    for (int i = 0; i < 8; i++) expTags[2*i +: 2] = mTag[(mTop + i) % 8];
    check(topPtr == 3'(mTop), req, "topPtr", 80'(topPtr), 80'(mTop));
    check(tagWord == expTags, req, "tagWord", 80'(tagWord), 80'(expTags));
    check(stackFault == mFault, "R10", "stackFault", 80'(stackFault), 80'(mFault));
    check(invalidOp == mFault, "R10", "invalidOp", 80'(invalidOp), 80'(mFault));
    for (int s = 0; s < 8; s++) begin
      rdSlot = 3'(s);
      #0.5;
      check(rdData == mReg[(mTop + s) % 8], "R2", $sformatf("rdData slot %0d", s),
            rdData, mReg[(mTop + s) % 8]);
    end
  endtask

  // R11: drive at falling edge, sampled at the next rising edge, compared at the following falling edge.
  task automatic doCmd(input int op, input int sel, input logic [79:0] d, input string req);
    cmdOp = 3'(op); slotSel = 3'(sel); wrData = d;
    @(posedge clk);
    modelApply(op, sel, d);
    @(negedge clk);
    cmdOp = 3'd0;
    compareAll(req);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [79:0] pool [8];
    for (int k = 0; k < 8; k++) begin mReg[k] = '0; mTag[k] = 2'b11; end
    mTop = 0; mFault = 1'b0;
    pool[0] = V_ONE; pool[1] = V_TWO; pool[2] = V_NEGZ; pool[3] = V_INF;
    pool[4] = V_NAN; pool[5] = V_DENORM; pool[6] = V_UNNORM; pool[7] = V_NEGBIG;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1");

    doCmd(1, 0, V_ONE, "R3");
    doCmd(1, 0, V_TWO, "R3");
    doCmd(1, 0, V_NEGZ, "R9");
    doCmd(6, 2, '0, "R6");
    doCmd(6, 3, '0, "R6");       // empty slot: underflow
    doCmd(0, 0, '0, "R10");      // pulse must drop
    doCmd(4, 2, '0, "R7");
    doCmd(4, 5, '0, "R6");       // slot 5 empty
    doCmd(3, 1, V_INF, "R8");
    doCmd(3, 6, V_DENORM, "R8"); // store into an empty slot
    doCmd(2, 0, '0, "R5");
    doCmd(2, 0, '0, "R5");
    doCmd(2, 0, '0, "R5");
    doCmd(2, 0, '0, "R6");       // pop from empty
    doCmd(5, 0, '0, "R1");
    for (int k = 0; k < 8; k++) doCmd(1, 0, pool[k], "R9");
    doCmd(1, 0, V_ONE, "R4");    // full: overflow
    doCmd(1, 0, V_TWO, "R4");    // overflow on consecutive cycles
    doCmd(4, 7, '0, "R7");
    doCmd(5, 0, '0, "R1");
    doCmd(2, 0, '0, "R6");

    seed = 32'h1234_5678;
    for (int n = 0; n < 400; n++) begin
      int op, sel, vi;
      seed = seed * 1103515245 + 12345;
      op = int'((seed >> 16) % 16);
      sel = int'((seed >> 8) % 8);
      vi = int'((seed >> 4) % 8);
      if (op > 6) op = (op < 11) ? 1 : 2;  // weight pushes and pops
      if (op == 5 && (seed & 32'h300) != 0) op = 0;
      doCmd(op, sel, pool[vi] ^ {16'h0, 64'(n)}, "R11");
    end

    summary();
    $finish;
  end
endmodule